// File: doc/BRIEF.md
# Serial Link Error Monitor

This block watches one serial receive link made of a deserializer and an optical module. It takes three status pins: the module's signal-detect level, and the deserializer's receive-valid and receive-error flags. The pins arrive asynchronously, so they pass through a multi-stage synchronizer before any logic uses them. Each synchronized sample is sorted into one class. Normal traffic is signal present, valid high and error low. Every other combination is recorded in a sticky status bit. A 10-bit saturating counter can also count carrier-extend words, error-propagation words, or both.

A sustained idle pattern marks a synchronization interval. Receive-valid and receive-error must both be low for at least three consecutive samples. While that interval lasts, the sticky bits and the counter are held clear. Accumulation therefore starts again after every resynchronization of the link.

The block also holds the six transceiver control levels in a read/write field. Software reaches everything through a two-word, 16-bit register port that reads combinationally.

Top module: `link_err_monitor`

## Requirements
- R1: After reset, the control field, all sticky bits, both count-select bits and the counter are zero. The live status bits read as signal present, valid high and error low.
- R2: Word 0 bits [5:0] are read/write control levels, driven straight to the outputs. The bits are: 0 transmitter disable, 1 deserializer enable, 2 loopback, 3 PRBS enable, 4 transmit enable, 5 transmit-error coding. Writes to word 0 bits [15:6] have no effect.
- R3: Word 0 bits 6, 7 and 8 read the synchronized signal-detect, receive-valid and receive-error levels, two register clocks after the pins.
- R4: A sample with signal-detect low sets sticky bit 9 (signal lost), whatever the other two flags are.
- R5: A sample with signal-detect high, valid low and error low sets sticky bit 10 (idle seen).
- R6: A sample with signal-detect high, valid low and error high sets sticky bit 11 (carrier extend).
- R7: A sample with signal-detect high, valid high and error high sets sticky bit 12 (error propagation). A normal sample changes no sticky bit. Sticky bits never clear except by R8.
- R8: The third and every later consecutive sample with valid low and error low clears all sticky bits and the counter, whatever the signal-detect level. One or two such samples clear nothing.
- R9: Word 1 bit 10 enables counting of carrier-extend samples and bit 11 enables counting of error-propagation samples. Each selected sample with signal-detect high adds one. Unselected classes and samples with signal lost add nothing.
- R10: The counter in word 1 bits [9:0] stops at 1023 and does not wrap.
- R11: Writes to word 1 change only bits 10 and 11. The counter bits ignore writes, and bits [15:12] read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and monitor clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_detect_i | input | 1 | Optical module signal-detect level (asynchronous) |
| rx_valid_i | input | 1 | Deserializer receive-valid flag (asynchronous) |
| rx_error_i | input | 1 | Deserializer receive-error flag (asynchronous) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Word select: 0 control/status, 1 counter |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for the selected word |
| tx_disable_o | output | 1 | Optical transmitter disable |
| serdes_en_o | output | 1 | Deserializer enable (low selects power down) |
| loopback_o | output | 1 | Deserializer loopback enable |
| prbs_en_o | output | 1 | Deserializer PRBS test enable |
| tx_en_o | output | 1 | Transmit enable |
| tx_err_code_o | output | 1 | Transmit error coding |

## Verification
Some properties are checked on every cycle by assertions. Sticky bits only rise outside a synchronization interval, and a normal sample leaves them untouched. A synchronization interval empties them and the counter. The counter moves by at most one per cycle and holds at its maximum. The control and count-select fields change only on a write to their own word.

Other behaviours can only be shown by the bench's scenarios. These include the mapping of each flag combination to its sticky bit, the rule that two idle samples do not clear, and the counted totals under each count selection. Long random mixtures, checked against a reference model, cover how class, select bits and resynchronization interact.

// File: rtl/lkmon_pkg.sv
package lkmon_pkg;

   typedef struct packed {
      logic sd;
      logic dv;
      logic er;
   } lk_sample_t;

   localparam lk_sample_t SAMPLE_NORMAL = '{sd: 1'b1, dv: 1'b1, er: 1'b0};

   localparam int CTRL_W     = 6;
   localparam int LIVE_LSB   = 6;
   localparam int STICKY_LSB = 9;
   localparam int STICKY_W   = 4;

   localparam int ST_LOS  = 0;
   localparam int ST_IDLE = 1;
   localparam int ST_CE   = 2;
   localparam int ST_EP   = 3;

   localparam int CT_TXDIS = 0;
   localparam int CT_ENA   = 1;
   localparam int CT_LOOP  = 2;
   localparam int CT_PRBS  = 3;
   localparam int CT_TXEN  = 4;
   localparam int CT_TXER  = 5;

endpackage

// File: rtl/lkmon_sync.sv
module lkmon_sync #(
   parameter int          WIDTH   = 3,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lkmon_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("lkmon_sync: WIDTH must be positive");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/lkmon_classify.sv
module lkmon_classify
   import lkmon_pkg::*;
#(
   parameter int IDLE_RUN = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  lk_sample_t          smp,
   output logic [STICKY_W-1:0] sticky_o,
   output logic                in_sync_o,
   output logic                ce_word_o,
   output logic                ep_word_o
);

   localparam int RUN_W = $clog2(IDLE_RUN + 1);
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(IDLE_RUN - 1);

   generate
      if (IDLE_RUN < 1) begin : g_bad_run
         $error("lkmon_classify: IDLE_RUN must be at least 1");
      end
   endgenerate

   logic                is_idle;
   logic [RUN_W-1:0]    run_q;
   logic [STICKY_W-1:0] hit;
   logic [STICKY_W-1:0] sticky_q;

   assign is_idle   = !smp.dv && !smp.er;
   assign in_sync_o = is_idle && (run_q >= RUN_LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= '0;
      end else if (!is_idle) begin
         run_q <= '0;
      end else if (run_q < RUN_LAST) begin
         run_q <= run_q + 1'b1;
      end
   end

   always_comb begin
      hit          = '0;
      hit[ST_LOS]  = !smp.sd;
      hit[ST_IDLE] = smp.sd && is_idle;
      hit[ST_CE]   = smp.sd && !smp.dv && smp.er;
      hit[ST_EP]   = smp.sd && smp.dv && smp.er;
   end

   assign ce_word_o = hit[ST_CE];
   assign ep_word_o = hit[ST_EP];

   always_ff @(posedge clk) begin
      if (rst) begin
         sticky_q <= '0;
      end else if (in_sync_o) begin
         sticky_q <= '0;
      end else begin
         sticky_q <= sticky_q | hit;
      end
   end

   assign sticky_o = sticky_q;

   // R8: a synchronization sample empties every sticky bit on the next cycle
   assert_sync_clears_R8: assert property (@(posedge clk) disable iff (rst)
      in_sync_o |=> (sticky_o == '0));

   // R7: outside synchronization no sticky bit ever falls
   assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !in_sync_o |=> ((sticky_o & $past(sticky_o)) == $past(sticky_o)));

   // R7: a normal sample leaves the sticky bits unchanged
   assert_normal_quiet_R7: assert property (@(posedge clk) disable iff (rst)
      (smp == SAMPLE_NORMAL) |=> (sticky_o == $past(sticky_o)));

endmodule

// File: rtl/lkmon_errcnt.sv
module lkmon_errcnt #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("lkmon_errcnt: CNT_W must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt_q <= '0;
      end else if (inc && (cnt_q != CNT_MAX)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;

   // R10: once at the maximum the counter stays there until cleared
   assert_saturate_R10: assert property (@(posedge clk) disable iff (rst)
      ((cnt_o == CNT_MAX) && !clr) |=> (cnt_o == CNT_MAX));

   // R9: the count moves by at most one per cycle
   assert_single_step_R9: assert property (@(posedge clk) disable iff (rst)
      !clr |=> ((cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 1'b1)));

   // R8: synchronization clears the counter
   assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
      clr |=> (cnt_o == '0));

endmodule

// File: rtl/lkmon_regs.sv
module lkmon_regs
   import lkmon_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 10
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr,
   input  logic                sel,
   input  logic [DATA_W-1:0]   wdata,
   input  lk_sample_t          live,
   input  logic [STICKY_W-1:0] sticky,
   input  logic [CNT_W-1:0]    cnt,
   output logic [DATA_W-1:0]   rdata,
   output logic [CTRL_W-1:0]   ctrl_o,
   output logic                sel_ce_o,
   output logic                sel_ep_o
);

   localparam int SEL_CE_BIT = CNT_W;
   localparam int SEL_EP_BIT = CNT_W + 1;

   generate
      if (CNT_W + 2 > DATA_W) begin : g_bad_cnt
         $error("lkmon_regs: counter plus select bits exceed the word");
      end
      if (STICKY_LSB + STICKY_W > DATA_W) begin : g_bad_sticky
         $error("lkmon_regs: status field exceeds the word");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_q;
   logic              sel_ce_q;
   logic              sel_ep_q;
   logic              unused_wdata;

   assign unused_wdata = ^wdata;

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q   <= '0;
         sel_ce_q <= 1'b0;
         sel_ep_q <= 1'b0;
      end else if (wr) begin
         if (!sel) begin
            ctrl_q <= wdata[CTRL_W-1:0];
         end else begin
            sel_ce_q <= wdata[SEL_CE_BIT];
            sel_ep_q <= wdata[SEL_EP_BIT];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (!sel) begin
         rdata[CTRL_W-1:0]            = ctrl_q;
         rdata[LIVE_LSB]              = live.sd;
         rdata[LIVE_LSB+1]            = live.dv;
         rdata[LIVE_LSB+2]            = live.er;
         rdata[STICKY_LSB +: STICKY_W] = sticky;
      end else begin
         rdata[CNT_W-1:0]  = cnt;
         rdata[SEL_CE_BIT] = sel_ce_q;
         rdata[SEL_EP_BIT] = sel_ep_q;
      end
   end

   assign ctrl_o   = ctrl_q;
   assign sel_ce_o = sel_ce_q;
   assign sel_ep_o = sel_ep_q;

   // R2: a write to word 0 lands in the control field
   assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (rst)
      (wr && !sel) |=> (ctrl_o == $past(wdata[CTRL_W-1:0])));

   // R2: the control field moves only on a word 0 write
   assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !(wr && !sel) |=> $stable(ctrl_o));

   // R11: count selects move only on a word 1 write
   assert_sel_hold_R11: assert property (@(posedge clk) disable iff (rst)
      !(wr && sel) |=> ($stable(sel_ce_o) && $stable(sel_ep_o)));

endmodule

// File: rtl/link_err_monitor.sv
module link_err_monitor
   import lkmon_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int CNT_W       = 10,
   parameter int IDLE_RUN    = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sig_detect_i,
   input  logic              rx_valid_i,
   input  logic              rx_error_i,
   input  logic              reg_wr_i,
   input  logic              reg_sel_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              tx_disable_o,
   output logic              serdes_en_o,
   output logic              loopback_o,
   output logic              prbs_en_o,
   output logic              tx_en_o,
   output logic              tx_err_code_o
);

   localparam int SMP_W = $bits(lk_sample_t);

   lk_sample_t          pin_smp;
   lk_sample_t          smp;
   logic [SMP_W-1:0]    smp_bits;
   logic [STICKY_W-1:0] sticky;
   logic                in_sync;
   logic                ce_word;
   logic                ep_word;
   logic                sel_ce;
   logic                sel_ep;
   logic                cnt_inc;
   logic [CNT_W-1:0]    cnt;
   logic [CTRL_W-1:0]   ctrl;

   assign pin_smp = '{sd: sig_detect_i, dv: rx_valid_i, er: rx_error_i};

   lkmon_sync #(
      .WIDTH   (SMP_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SAMPLE_NORMAL)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (pin_smp),
      .q   (smp_bits)
   );

   assign smp = lk_sample_t'(smp_bits);

   lkmon_classify #(
      .IDLE_RUN (IDLE_RUN)
   ) u_classify (
      .clk       (clk),
      .rst       (rst),
      .smp       (smp),
      .sticky_o  (sticky),
      .in_sync_o (in_sync),
      .ce_word_o (ce_word),
      .ep_word_o (ep_word)
   );

   assign cnt_inc = (sel_ce && ce_word) || (sel_ep && ep_word);

   lkmon_errcnt #(
      .CNT_W (CNT_W)
   ) u_errcnt (
      .clk   (clk),
      .rst   (rst),
      .clr   (in_sync),
      .inc   (cnt_inc),
      .cnt_o (cnt)
   );

   lkmon_regs #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_regs (
      .clk      (clk),
      .rst      (rst),
      .wr       (reg_wr_i),
      .sel      (reg_sel_i),
      .wdata    (reg_wdata_i),
      .live     (smp),
      .sticky   (sticky),
      .cnt      (cnt),
      .rdata    (reg_rdata_o),
      .ctrl_o   (ctrl),
      .sel_ce_o (sel_ce),
      .sel_ep_o (sel_ep)
   );

   assign tx_disable_o  = ctrl[CT_TXDIS];
   assign serdes_en_o   = ctrl[CT_ENA];
   assign loopback_o    = ctrl[CT_LOOP];
   assign prbs_en_o     = ctrl[CT_PRBS];
   assign tx_en_o       = ctrl[CT_TXEN];
   assign tx_err_code_o = ctrl[CT_TXER];

   // R9: the counter only advances when a selected class is present
   assert_count_needs_word_R9: assert property (@(posedge clk) disable iff (rst)
      (!cnt_inc && !in_sync) |=> $stable(cnt));

endmodule

// File: tb/link_err_monitor_bench.sv
`timescale 1ns/1ps
module link_err_monitor_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        sd = 1'b1, dv = 1'b1, er = 1'b0;
   logic        wr = 1'b0, sel = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        o_txdis, o_ena, o_loop, o_prbs, o_txen, o_txer;

   int n_tests = 0;
   int n_fail  = 0;

   // reference model state
   int         m_run = 0;
   logic [3:0] m_st  = '0;
   int         m_cnt = 0;
   bit         m_sce = 0, m_sep = 0;
   logic [5:0] m_ctrl = '0;

   always #2.5 clk = ~clk;

   link_err_monitor u_link_err_monitor (
      .clk           (clk),
      .rst           (rst),
      .sig_detect_i  (sd),
      .rx_valid_i    (dv),
      .rx_error_i    (er),
      .reg_wr_i      (wr),
      .reg_sel_i     (sel),
      .reg_wdata_i   (wdata),
      .reg_rdata_o   (rdata),
      .tx_disable_o  (o_txdis),
      .serdes_en_o   (o_ena),
      .loopback_o    (o_loop),
      .prbs_en_o     (o_prbs),
      .tx_en_o       (o_txen),
      .tx_err_code_o (o_txer)
   );

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [15:0] exp_w0();
      return {3'b000, m_st, 3'b011, m_ctrl};
   endfunction

   function automatic logic [15:0] exp_w1();
      return {4'b0000, m_sep, m_sce, 10'(m_cnt)};
   endfunction

   task automatic model_step(input logic s, input logic v, input logic e);
      bit idle;
      idle = !v && !e;
      if (idle) begin
         if (m_run < 3) m_run++;
      end else begin
         m_run = 0;
      end
      if (idle && m_run >= 3) begin
         m_st  = '0;
         m_cnt = 0;
      end else begin
         if (!s)              m_st[0] = 1'b1;
         if (s && idle)       m_st[1] = 1'b1;
         if (s && !v && e)    m_st[2] = 1'b1;
         if (s && v && e)     m_st[3] = 1'b1;
         if (s && e && ((!v && m_sce) || (v && m_sep)) && m_cnt < 1023) m_cnt++;
      end
   endtask

   task automatic step(input logic s, input logic v, input logic e);
      @(negedge clk);
      sd = s; dv = v; er = e;
      model_step(s, v, e);
   endtask

   task automatic flush();
      for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0);
   endtask

   task automatic resync();
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0);
      flush();
   endtask

   task automatic rd(input logic s, output logic [15:0] d);
      @(negedge clk);
      sel = s;
      #1 d = rdata;
   endtask

   task automatic wrw(input logic s, input logic [15:0] d);
      @(negedge clk);
      wr = 1'b1; sel = s; wdata = d;
      @(negedge clk);
      wr = 1'b0;
      if (!s) m_ctrl = d[5:0];
      else begin
         m_sce = d[10];
         m_sep = d[11];
      end
   endtask

   task automatic check_both(input string req);
      logic [15:0] d;
      rd(1'b0, d); chk(req, d, exp_w0());
      rd(1'b1, d); chk(req, d, exp_w1());
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] d;
      void'($urandom(32'd20517));
      repeat (4) @(negedge clk);
      rst = 1'b0;

      // R1 reset state
      check_both("R1");
      chk("R1 outputs", {10'd0, o_txer, o_txen, o_prbs, o_loop, o_ena, o_txdis}, 16'h0000);

      // R2 control read/write, upper bits ignored
      wrw(1'b0, 16'hFFFF);
      rd(1'b0, d); chk("R2 all ones", d, exp_w0());
      chk("R2 outputs", {10'd0, o_txer, o_txen, o_prbs, o_loop, o_ena, o_txdis}, 16'h003F);
      wrw(1'b0, 16'hAA15);
      rd(1'b0, d); chk("R2 pattern", d, exp_w0());
      chk("R2 pattern outputs", {10'd0, o_txer, o_txen, o_prbs, o_loop, o_ena, o_txdis}, 16'h0015);

      // R3 live status, R4 lost signal
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1);
      rd(1'b0, d); chk("R3 live", {13'd0, d[8:6]}, 16'h0006);
      flush();
      rd(1'b0, d); chk("R4 lost signal", d, exp_w0());

      // R5 short idle sets idle bit, R8 two samples do not clear
      step(1'b1, 1'b0, 1'b0); step(1'b1, 1'b0, 1'b0);
      flush();
      rd(1'b0, d); chk("R5 R8 short idle", d, exp_w0());
      chk("R8 no clear on two", {12'd0, d[12:9]}, 16'h0003);

      // R8 three idle samples clear
      resync();
      rd(1'b0, d); chk("R8 cleared", {12'd0, d[12:9]}, 16'h0000);

      // R6 carrier extend, not counted when unselected (R9)
      step(1'b1, 1'b0, 1'b1);
      flush();
      check_both("R6 R9");

      // R7 error propagation, normal words change nothing
      resync();
      step(1'b1, 1'b1, 1'b1);
      for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0);
      rd(1'b0, d); chk("R7", d, exp_w0());
      chk("R7 only ep", {12'd0, d[12:9]}, 16'h0008);

      // R9 count selection variants
      resync(); wrw(1'b1, 16'h0400);
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1);
      for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1);
      step(1'b0, 1'b1, 1'b1);
      flush(); rd(1'b1, d); chk("R9 ce only", d, 16'h0405);
      resync(); wrw(1'b1, 16'h0800);
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1);
      for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1);
      flush(); rd(1'b1, d); chk("R9 ep only", d, 16'h0803);
      resync(); wrw(1'b1, 16'h0C00);
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1);
      for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1);
      flush(); rd(1'b1, d); chk("R9 both", d, 16'h0C08);

      // R10 saturation
      for (int i = 0; i < 1030; i++) step(1'b1, 1'b1, 1'b1);
      flush(); rd(1'b1, d); chk("R10 saturate", d, 16'h0FFF);
      step(1'b1, 1'b0, 1'b1); flush();
      rd(1'b1, d); chk("R10 hold", d, 16'h0FFF);

      // R11 counter bits ignore writes
      wrw(1'b1, 16'hF3FF);
      rd(1'b1, d); chk("R11 write", d, 16'h03FF);
      chk("R11 model", d, exp_w1());

      // R8 counter cleared by resync
      resync();
      rd(1'b1, d); chk("R8 counter clear", d, 16'h0000);

      // random mixtures
      for (int r = 0; r < 40; r++) begin
         wrw(1'b1, 16'($urandom % 4) << 10);
         wrw(1'b0, 16'($urandom));
         for (int i = 0; i < 30; i++) begin
            int k;
            k = $urandom % 8;
            case (k)
               0, 1, 2: step(1'b1, 1'b1, 1'b0);
               3:       step(1'b1, 1'b0, 1'b0);
               4:       step(1'b1, 1'b0, 1'b1);
               5:       step(1'b1, 1'b1, 1'b1);
               6:       step(1'b0, 1'($urandom), 1'($urandom));
               default: step(1'($urandom), 1'b0, 1'b0);
            endcase
         end
         flush();
         check_both("R4 R5 R6 R7 R8 R9 random");
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule